// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Controller

This block lets logic running on one clock reach an external 256K-word by 16-bit pseudo-static RAM that has an asynchronous interface. The synchronous side has a request port with a valid/ready handshake. Each request carries a read/write select, an 18-bit word address, 16 bits of write data and a 2-bit byte mask. A read returns its data together with a one-cycle valid pulse.

The memory side drives the active-low chip enable, output enable, write enable and upper and lower byte-lane enables, the address bus, and a data bus that is split into an output value, an output enable and an input. The parameters hold the read access time, the write pulse width and the cycle time in nanoseconds. The block turns these into clock counts, rounding up.

Each access follows the same path. The address and lanes are set up for one cycle before chip enable falls. The strobes stay low for the counted access window. Address and lanes are then held for one cycle after the strobes rise, and a recovery interval pads the access out to the full cycle time.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is high and afterwards until the first request, all five memory strobes are high (1), `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access has completed, and requests presented while it is 0 do not change any memory-side output.
- R3: The address and lane enables change on the accepting edge, one cycle before chip enable falls. They stay stable until one full cycle after the strobes rise (the hold cycle).
- R4: A read holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for RA = max(ceil(T_RD_ACCESS_NS/CLK_PERIOD_NS), ceil(T_OE_NS/CLK_PERIOD_NS)) cycles. It drives both lane enables low whatever `req_mask` holds.
- R5: A read samples `mem_dq_i` on the edge that ends the access window, which is the edge where output enable rises. `rsp_rdata` shows that word during a single-cycle `rsp_valid` pulse in the hold cycle.
- R6: A write holds `mem_ce_n` and `mem_we_n` low with `mem_oe_n` high for WA = ceil(T_WR_PULSE_NS/CLK_PERIOD_NS) cycles. It sets `mem_lb_n` = !req_mask[0] (bits 7:0) and `mem_ub_n` = !req_mask[1] (bits 15:8).
- R7: `mem_dq_oe` is 1 only during a write's access window and its hold cycle, with `mem_dq_o` equal to the write data. It is never 1 while output enable is low.
- R8: A write with `req_mask` = 0 leaves every strobe and both lanes high for the whole operation. `req_ready` returns after one setup cycle plus the write recovery interval.
- R9: After the hold cycle, recovery lasts max(1, ceil(T_CYCLE_NS/CLK_PERIOD_NS) - A - 2) cycles, where A is RA or WA. `req_ready` returns to 1 on the edge that ends recovery.
- R10: Output enable and write enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_addr | output | 18 | Memory address bus |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data returned from memory |

## Verification
Two events share one clock edge: the capture of read data and the rise of output enable. The device model in the bench drives the data bus only while chip and output enable are both low. An early or late sample therefore returns zero rather than the stored word, and the check against the bench's own memory image catches it. A second overlap also gets attention: a request held valid through a busy access, with a different address and opcode, reaches the end of recovery. The memory-side address must not move before `req_ready` returns. The next operation must begin on the edge right after that.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_RECOVER
  } ps_state_e;

  function automatic int cycles_for(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_req_reg.sv
module psram_req_reg #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              in_we,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [LANES-1:0]  in_mask,
  output logic              is_wr,
  output logic              noop,
  output logic [DATA_W-1:0] wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      is_wr <= 1'b0;
      noop  <= 1'b0;
      wdata <= '0;
    end else if (accept) begin
      is_wr <= in_we;
      noop  <= in_we && (in_mask == '0);
      wdata <= in_wdata;
    end
  end

endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_ctrl_pkg::*;
#(
  parameter int RD_ACC = 7,
  parameter int WR_ACC = 5,
  parameter int RD_REC = 1,
  parameter int WR_REC = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      accept,
  input  logic      is_wr,
  input  logic      noop,
  output ps_state_e state_q,
  output ps_state_e state_d
);

  localparam int MAX_CNT = max2(max2(RD_ACC, WR_ACC), max2(RD_REC, WR_REC));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (noop) begin
          state_d = ST_RECOVER;
          cnt_d   = CNT_W'(WR_REC - 1);
        end else begin
          state_d = ST_ACCESS;
          cnt_d   = is_wr ? CNT_W'(WR_ACC - 1) : CNT_W'(RD_ACC - 1);
        end
      end
      ST_ACCESS: begin
        if (cnt_q == '0) state_d = ST_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        state_d = ST_RECOVER;
        cnt_d   = is_wr ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
      end
      ST_RECOVER: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/psram_pins.sv
module psram_pins
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  input  logic              is_wr,
  input  logic [DATA_W-1:0] wdata,
  input  ps_state_e         state_q,
  input  ps_state_e         state_d,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [LANES-1:0]  lane_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);

  logic going_access, ending_access, first_access;

  assign going_access  = (state_d == ST_ACCESS);
  assign ending_access = (state_q == ST_ACCESS) && (state_d == ST_HOLD);
  assign first_access  = (state_q == ST_SETUP) && going_access;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready  <= 1'b1;
      rvalid <= 1'b0;
      rdata  <= '0;
      ce_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      addr   <= '0;
      dq_o   <= '0;
      dq_oe  <= 1'b0;
    end else begin
      ready  <= (state_d == ST_IDLE);
      ce_n   <= !going_access;
      oe_n   <= !(going_access && !is_wr);
      we_n   <= !(going_access && is_wr);
      dq_oe  <= is_wr && (going_access || state_d == ST_HOLD);
      rvalid <= ending_access && !is_wr;
      if (accept)                    addr  <= req_addr;
      if (first_access && is_wr)     dq_o  <= wdata;
      if (ending_access && !is_wr)   rdata <= dq_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk) begin
      if (rst)                      lane_q <= 1'b1;
      else if (accept)              lane_q <= req_we ? !req_mask[g] : 1'b0;
      else if (state_q == ST_HOLD)  lane_q <= 1'b1;
    end
    assign lane_n[g] = lane_q;
  end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int DATA_W         = 16,
  parameter int CLK_PERIOD_NS  = 10,
  parameter int T_RD_ACCESS_NS = 70,
  parameter int T_OE_NS        = 25,
  parameter int T_WR_PULSE_NS  = 45,
  parameter int T_CYCLE_NS     = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int LANES   = DATA_W / 8;
  localparam int RD_ACC  = max2(cycles_for(T_RD_ACCESS_NS, CLK_PERIOD_NS),
                                cycles_for(T_OE_NS, CLK_PERIOD_NS));
  localparam int WR_ACC  = at_least_one(cycles_for(T_WR_PULSE_NS, CLK_PERIOD_NS));
  localparam int CYC     = cycles_for(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int RD_REC  = at_least_one(CYC - RD_ACC - 2);
  localparam int WR_REC  = at_least_one(CYC - WR_ACC - 2);

  logic              accept;
  logic              is_wr, noop;
  logic [DATA_W-1:0] wdata;
  logic [LANES-1:0]  lane_n;
  ps_state_e         state_q, state_d;

  assign accept = req_valid && req_ready;

  psram_req_reg #(.DATA_W(DATA_W), .LANES(LANES)) u_req (
    .clk(clk), .rst(rst), .accept(accept),
    .in_we(req_we), .in_wdata(req_wdata), .in_mask(req_mask),
    .is_wr(is_wr), .noop(noop), .wdata(wdata)
  );

  psram_seq #(
    .RD_ACC(RD_ACC), .WR_ACC(WR_ACC), .RD_REC(RD_REC), .WR_REC(WR_REC)
  ) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .is_wr(is_wr), .noop(noop),
    .state_q(state_q), .state_d(state_d)
  );

  psram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
    .clk(clk), .rst(rst), .accept(accept),
    .req_we(req_we), .req_addr(req_addr), .req_mask(req_mask),
    .is_wr(is_wr), .wdata(wdata), .state_q(state_q), .state_d(state_d),
    .dq_i(mem_dq_i),
    .ready(req_ready), .rvalid(rsp_valid), .rdata(rsp_rdata),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .lane_n(lane_n),
    .addr(mem_addr), .dq_o(mem_dq_o), .dq_oe(mem_dq_oe)
  );

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[LANES-1];

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  a_r10_oe_we_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  a_r7_drive_not_reading: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r3_setup_before_ce: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));

  a_r3_addr_stable_under_ce: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r3_hold_after_ce: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |=> $stable(mem_addr));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r5_valid_with_oe_rise: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(mem_oe_n));

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r4_read_both_lanes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ub_n && !mem_lb_n));

endmodule

bind psram_ctrl psram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_psram_ctrl.sv
module tb_psram_ctrl;

  localparam int CLK_NS = 10;
  localparam int T_RD = 70, T_OE = 25, T_WP = 45, T_CY = 100;
  localparam int RA  = ((T_RD + CLK_NS - 1) / CLK_NS) > ((T_OE + CLK_NS - 1) / CLK_NS)
                     ? ((T_RD + CLK_NS - 1) / CLK_NS) : ((T_OE + CLK_NS - 1) / CLK_NS);
  localparam int WA  = (T_WP + CLK_NS - 1) / CLK_NS;
  localparam int CYN = (T_CY + CLK_NS - 1) / CLK_NS;
  localparam int RREC = (CYN - RA - 2) < 1 ? 1 : (CYN - RA - 2);
  localparam int WREC = (CYN - WA - 2) < 1 ? 1 : (CYN - WA - 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;

  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  psram_ctrl #(
    .ADDR_W(18), .DATA_W(16), .CLK_PERIOD_NS(CLK_NS), .T_RD_ACCESS_NS(T_RD),
    .T_OE_NS(T_OE), .T_WR_PULSE_NS(T_WP), .T_CYCLE_NS(T_CY)
  ) dut (.*);

  // Device model: drives data only while chip and output enable are low
  logic [15:0] dev_mem [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] init_word(input logic [17:0] a);
    return a[15:0] ^ 16'h5AC3;
  endfunction

  function automatic logic [15:0] dev_word(input logic [17:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : init_word(a);
  endfunction

  function automatic logic [15:0] ref_word(input logic [17:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
  endfunction

  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_i = {mem_ub_n ? 8'h00 : dev_word(mem_addr)[15:8],
                  mem_lb_n ? 8'h00 : dev_word(mem_addr)[7:0]};
    else
      mem_dq_i = 16'h0000;
  end

  logic        p_we = 1'b1, p_ce = 1'b1, p_ub = 1'b1, p_lb = 1'b1, p_oe = 1'b0;
  logic [17:0] p_addr = '0;
  logic [15:0] p_dq = '0;

  always @(negedge clk) begin
    if (!p_we && mem_we_n && !p_ce && p_oe) begin
      logic [15:0] w;
      w = dev_word(p_addr);
      if (!p_lb) w[7:0]  = p_dq[7:0];
      if (!p_ub) w[15:8] = p_dq[15:8];
      dev_mem[int'(p_addr)] = w;
    end
    p_we = mem_we_n; p_ce = mem_ce_n; p_ub = mem_ub_n; p_lb = mem_lb_n;
    p_addr = mem_addr; p_dq = mem_dq_o; p_oe = mem_dq_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Issue one operation at a negedge and follow it cycle by cycle
  task automatic run_op(input bit wr, input logic [17:0] a, input logic [1:0] m,
                        input logic [15:0] d, input bit spam);
    bit          noop;
    int          acc, rec, last;
    logic [15:0] exp_rd, nw;
    noop = wr && (m == 2'b00);
    acc  = wr ? WA : RA;
    rec  = wr ? WREC : RREC;
    last = noop ? (1 + rec) : (acc + 2 + rec);
    exp_rd = ref_word(a);
    req_valid = 1'b1; req_we = wr; req_addr = a; req_mask = m; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (spam) begin
      req_addr = ~a; req_we = !wr; req_mask = ~m; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k <= last; k++) begin
      bit in_acc, hold;
      logic [1:0] e_lane;
      in_acc = !noop && k >= 1 && k <= acc;
      hold   = !noop && k == acc + 1;
      if (k <= acc + 1 && !noop) e_lane = wr ? ~m : 2'b00;
      else                       e_lane = 2'b11;
      chk(wr ? "R6 ce_n" : "R4 ce_n", 32'(mem_ce_n), 32'(!in_acc));
      chk(wr ? "R6 oe_n" : "R4 oe_n", 32'(mem_oe_n), 32'(!(in_acc && !wr)));
      chk(wr ? "R6 we_n" : "R4 we_n", 32'(mem_we_n), 32'(!(in_acc && wr)));
      chk(noop ? "R8 lanes" : "R3 lanes", 32'({mem_ub_n, mem_lb_n}), 32'(e_lane));
      chk("R7 dq_oe", 32'(mem_dq_oe), 32'(wr && (in_acc || hold)));
      chk("R5 rsp_valid", 32'(rsp_valid), 32'(!wr && hold));
      chk(noop ? "R8 ready" : "R9 ready", 32'(req_ready), 32'(k == last));
      if (k <= acc + 1) chk(spam ? "R2 addr" : "R3 addr", 32'(mem_addr), 32'(a));
      if (wr && (in_acc || hold)) chk("R7 dq_o", 32'(mem_dq_o), 32'(d));
      if (!wr && hold) chk("R5 rdata", 32'(rsp_rdata), 32'(exp_rd));
      if (k == last) req_valid = 1'b0;
      else @(negedge clk);
    end
    if (wr && !noop) begin
      nw = ref_word(a);
      if (m[0]) nw[7:0]  = d[7:0];
      if (m[1]) nw[15:8] = d[15:8];
      ref_mem[int'(a)] = nw;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    chk("R1 strobes in reset", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1F);
    chk("R1 dq_oe in reset", 32'(mem_dq_oe), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'h1);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk("R1 strobes idle", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1F);

    run_op(1'b0, 18'h00000, 2'b11, 16'h0000, 1'b0);   // R4 read of untouched word
    run_op(1'b1, 18'h00000, 2'b11, 16'hBEEF, 1'b0);   // R6 full write
    run_op(1'b0, 18'h00000, 2'b00, 16'h0000, 1'b0);   // R4 mask ignored on read
    run_op(1'b1, 18'h3FFFF, 2'b01, 16'h1234, 1'b0);   // R6 low lane only
    run_op(1'b0, 18'h3FFFF, 2'b10, 16'h0000, 1'b0);   // R5 read back
    run_op(1'b1, 18'h3FFFF, 2'b10, 16'hA9FF, 1'b0);   // R6 high lane only
    run_op(1'b0, 18'h3FFFF, 2'b11, 16'h0000, 1'b0);
    run_op(1'b1, 18'h12345, 2'b00, 16'hDEAD, 1'b0);   // R8 zero-mask write
    run_op(1'b0, 18'h12345, 2'b11, 16'h0000, 1'b0);   // R8 word left untouched
    run_op(1'b1, 18'h0AAAA, 2'b11, 16'h5555, 1'b1);   // R2 request held while busy
    run_op(1'b0, 18'h0AAAA, 2'b11, 16'h0000, 1'b1);   // R2 back-to-back read
    run_op(1'b1, 18'h00001, 2'b11, 16'hC0DE, 1'b0);
    run_op(1'b0, 18'h00001, 2'b01, 16'h0000, 1'b0);   // R5 R9
    repeat (3) @(negedge clk);
    chk("R2 idle without request", 32'(mem_ce_n), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule